// File: doc/BRIEF.md
# Display Refresh Address Mapper

The block keeps the linear refresh address counter that a display controller steps once per character clock and turns it into a video memory address for a frame buffer built as 64K words of 32 bits. At each frame start the counter reloads a start address and latches the frame's mode settings. After that it steps on enabled character clocks, or on every second enabled character clock when the count-by-two setting is on.

The counter value is mapped in three stages. In byte mode it is used as it is. In word mode it is shifted up one place, and the vacated low bit is filled from counter bit 13 or counter bit 15. With 64K of memory, the top two address bits are then cleared and bank 0 is used. With 256K of memory, the top two bits are kept and they also drive the bank select. The mapped address is registered, so it appears one clock after the counter value it comes from.

Top module: `refresh_addr_map`

## Requirements
- R1: While reset is asserted and after its release with no frame start, `mem_addr` is 0x0000 and `bank_sel` is 0.
- R2: A clock with `frame_start` high loads `start_addr` into the counter. This holds even when `char_clk_en` is high in the same clock.
- R3: With count-by-two off, each clock with `char_clk_en` high and `frame_start` low adds one to the counter. The counter wraps from 0xFFFF to 0x0000.
- R4: With count-by-two on, the counter steps only on every second enabled character clock. The first enabled character clock after a frame start does not step it.
- R5: With `word_mode` = 0 (byte mode) and `mem_256k` = 1, `mem_addr` equals the counter value.
- R6: With `word_mode` = 1, `mem_addr` is the counter shifted left by one place, with bit 0 taken from counter bit 13 when `mem_256k` = 0 or `addr_wrap` = 0. Example: counts 0x1FFE, 0x1FFF, 0x2000, 0x2001 give 0x3FFC, 0x3FFE, 0x4001, 0x4003 with 256K memory.
- R7: With `word_mode` = 1, `mem_256k` = 1 and `addr_wrap` = 1, bit 0 of `mem_addr` is counter bit 15. Example: count 0x8000 gives 0x0001.
- R8: With `mem_256k` = 0, bits 15:14 of `mem_addr` are zero and `bank_sel` is 0. The word-mode example in R6 then gives 0x3FFC, 0x3FFE, 0x0001, 0x0003.
- R9: With `mem_256k` = 1, `bank_sel` equals bits 15:14 of `mem_addr`, and those bits are not cleared.
- R10: `mem_addr` and `bank_sel` show the mapping of the counter value held in the previous clock, which is one clock of latency.
- R11: `count_by_two`, `word_mode`, `addr_wrap` and `mem_256k` are sampled only in a frame-start clock. A change at any other time has no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_clk_en | input | 1 | Character clock strobe, one clock wide |
| frame_start | input | 1 | Reloads the counter and latches the mode inputs |
| start_addr | input | 16 | Counter reload value |
| count_by_two | input | 1 | 1: step on every second character clock |
| word_mode | input | 1 | 0: byte mode, 1: word mode |
| addr_wrap | input | 1 | 1: word-mode fill bit from counter bit 15 (256K only) |
| mem_256k | input | 1 | 0: 64K memory, 1: 256K memory |
| mem_addr | output | 16 | Refresh memory address |
| bank_sel | output | 2 | Memory bank select |

## Verification
A frame start and an enabled character clock can fall in the same clock, and so can a frame start and a change of the mode inputs. The bench raises `char_clk_en` in every frame-start clock, then changes the mode pins partway through a frame. It checks that the reload wins and that the output keeps the old mapping until the next frame start. A behavioural model that uses integer arithmetic predicts `mem_addr` and `bank_sel` on every clock. It runs through both directed address sequences across the bit-13 and bit-15 boundaries and a long random mix of strobes, frame starts and mode settings.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam int ADDR_W  = 16;
  localparam int BANK_W  = 2;
  localparam int FILL_LO = 13;
  localparam int FILL_HI = 15;
  localparam int LOW_W   = ADDR_W - BANK_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    logic by_two;
    logic word;
    logic wrap;
    logic big_mem;
  } mode_t;

  function automatic logic fill_bit(addr_t c, mode_t m);
    return (!m.big_mem || !m.wrap) ? c[FILL_LO] : c[FILL_HI];
  endfunction

  function automatic addr_t shifted(addr_t c, mode_t m);
    return m.word ? {c[ADDR_W-2:0], fill_bit(c, m)} : c;
  endfunction

  function automatic addr_t sized(addr_t a, mode_t m);
    return m.big_mem ? a : {{BANK_W{1'b0}}, a[LOW_W-1:0]};
  endfunction

  function automatic bank_t bank_of(addr_t a, mode_t m);
    return m.big_mem ? a[ADDR_W-1 -: BANK_W] : '0;
  endfunction
endpackage

// File: rtl/rfa_mode_latch.sv
module rfa_mode_latch
  import rfa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  mode_t mode_in,
  output mode_t mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= '0;
    else if (frame_start) mode_q <= mode_in;
  end
endmodule

// File: rtl/rfa_counter.sv
module rfa_counter
  import rfa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  char_en,
  input  logic  by_two,
  input  addr_t start_addr,
  output addr_t cnt,
  output logic  step
);
  logic phase;

  // step: the counter moves on this clock edge
  assign step = !frame_start && char_en && (!by_two || phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (frame_start) begin
      cnt   <= start_addr;
      phase <= 1'b0;
    end else begin
      if (char_en && by_two) phase <= !phase;
      if (step)              cnt   <= cnt + addr_t'(1);
    end
  end
endmodule

// File: rtl/rfa_map.sv
module rfa_map
  import rfa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t cnt,
  input  mode_t mode,
  output addr_t mem_addr,
  output bank_t bank_sel
);
  addr_t next_addr;

  assign next_addr = sized(shifted(cnt, mode), mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      bank_sel <= '0;
    end else begin
      mem_addr <= next_addr;
      bank_sel <= bank_of(next_addr, mode);
    end
  end
endmodule

// File: rtl/refresh_addr_map.sv
module refresh_addr_map
  import rfa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        char_clk_en,
  input  logic        frame_start,
  input  logic [15:0] start_addr,
  input  logic        count_by_two,
  input  logic        word_mode,
  input  logic        addr_wrap,
  input  logic        mem_256k,
  output logic [15:0] mem_addr,
  output logic [1:0]  bank_sel
);
  mode_t mode_in;
  mode_t mode_q;
  addr_t cnt;
  logic  step;

  assign mode_in = '{by_two: count_by_two, word: word_mode,
                     wrap: addr_wrap, big_mem: mem_256k};

  rfa_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .mode_in(mode_in), .mode_q(mode_q)
  );

  rfa_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .char_en(char_clk_en), .by_two(mode_q.by_two),
    .start_addr(start_addr), .cnt(cnt), .step(step)
  );

  rfa_map u_map (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .mode(mode_q),
    .mem_addr(mem_addr), .bank_sel(bank_sel)
  );
endmodule

// File: rtl/rfa_chk.sv
module rfa_chk
  import rfa_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        char_clk_en,
  input logic        frame_start,
  input logic [15:0] start_addr,
  input addr_t       cnt,
  input logic        step,
  input mode_t       mode_q,
  input logic [15:0] mem_addr,
  input logic [1:0]  bank_sel
);
  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> cnt == $past(start_addr));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_clk_en && !frame_start && !mode_q.by_two) |=> cnt == addr_t'($past(cnt) + 16'd1));

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !step) |=> $stable(cnt));

  // R5
  byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.word && mode_q.big_mem) |=> mem_addr == $past(cnt));

  // R8
  small_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.big_mem |=> (bank_sel == 2'd0 && mem_addr[15:14] == 2'd0));

  // R9
  bank_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.big_mem |=> bank_sel == mem_addr[15:14]);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q));
endmodule

bind refresh_addr_map rfa_chk u_chk (
  .clk(clk), .rst_n(rst_n), .char_clk_en(char_clk_en),
  .frame_start(frame_start), .start_addr(start_addr), .cnt(cnt),
  .step(step), .mode_q(mode_q), .mem_addr(mem_addr), .bank_sel(bank_sel)
);

// File: tb/test_refresh_addr_map.sv
`timescale 1ns/1ps
module test_refresh_addr_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        char_clk_en = 1'b0;
  logic        frame_start = 1'b0;
  logic [15:0] start_addr = '0;
  logic        count_by_two = 1'b0;
  logic        word_mode = 1'b0;
  logic        addr_wrap = 1'b0;
  logic        mem_256k = 1'b0;
  logic [15:0] mem_addr;
  logic [1:0]  bank_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refresh_addr_map i_refresh_addr_map (
    .clk(clk), .rst_n(rst_n), .char_clk_en(char_clk_en),
    .frame_start(frame_start), .start_addr(start_addr),
    .count_by_two(count_by_two), .word_mode(word_mode),
    .addr_wrap(addr_wrap), .mem_256k(mem_256k),
    .mem_addr(mem_addr), .bank_sel(bank_sel)
  );

  // behavioural reference model
  int m_cnt, m_ph, m_by2, m_word, m_wrap, m_big;
  int exp_a, exp_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_by2 = 0; m_word = 0; m_wrap = 0; m_big = 0;
      exp_a = 0; exp_b = 0;
    end else begin
      int a, f;
      f = (m_big != 0 && m_wrap != 0) ? (m_cnt / 32768) % 2 : (m_cnt / 8192) % 2;
      a = (m_word != 0) ? (m_cnt * 2) % 65536 + f : m_cnt;
      if (m_big == 0) a = a % 16384;
      exp_a = a;
      exp_b = (m_big != 0) ? a / 16384 : 0;
      if (frame_start) begin
        m_cnt = start_addr; m_ph = 0;
        m_by2 = count_by_two; m_word = word_mode; m_wrap = addr_wrap; m_big = mem_256k;
      end else if (char_clk_en) begin
        if (m_by2 != 0) begin
          if (m_ph != 0) m_cnt = (m_cnt + 1) % 65536;
          m_ph = 1 - m_ph;
        end else begin
          m_cnt = (m_cnt + 1) % 65536;
        end
      end
    end
  end

  // per-clock comparison with the model (R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (mem_addr != exp_a[15:0] || bank_sel != exp_b[1:0]) begin
        errors++;
        $display("FAIL R10 model: addr=%h bank=%0d expected addr=%h bank=%0d",
                 mem_addr, bank_sel, exp_a[15:0], exp_b[1:0]);
      end
    end
  end

  task automatic check(input logic [15:0] ea, input logic [1:0] eb, input string tag);
    checks++;
    if (mem_addr !== ea || bank_sel !== eb) begin
      errors++;
      $display("FAIL %s: addr=%h bank=%0d expected addr=%h bank=%0d",
               tag, mem_addr, bank_sel, ea, eb);
    end
  endtask

  task automatic run_seq(input logic [15:0] st, input logic by2, input logic wd,
                         input logic wr, input logic big, input logic mid_flip,
                         input logic [3:0][15:0] ea, input logic [3:0][1:0] eb,
                         input string tag);
    @(negedge clk);
    frame_start = 1'b1; char_clk_en = 1'b1; start_addr = st;
    count_by_two = by2; word_mode = wd; addr_wrap = wr; mem_256k = big;
    @(negedge clk);
    frame_start = 1'b0;
    if (mid_flip) begin
      word_mode = ~wd; mem_256k = ~big; count_by_two = ~by2; addr_wrap = ~wr;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(ea[k], eb[k], tag);
    end
    char_clk_en = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check(16'h0000, 2'd0, "R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(16'h0000, 2'd0, "R1 after reset");

    // R6 R8 R2: bit-13 fill, 64K masking, reload with coincident strobe
    run_seq(16'h1FFE, 0, 1, 1, 0, 0, {16'h0003, 16'h0001, 16'h3FFE, 16'h3FFC},
            {2'd0, 2'd0, 2'd0, 2'd0}, "R6_R8_R2 word 64K");
    // R6 R9: bit-13 fill, 256K keeps high bits
    run_seq(16'h1FFE, 0, 1, 0, 1, 0, {16'h4003, 16'h4001, 16'h3FFE, 16'h3FFC},
            {2'd1, 2'd1, 2'd0, 2'd0}, "R6_R9 word 256K");
    // R7: bit-15 fill
    run_seq(16'h7FFF, 0, 1, 1, 1, 0, {16'h0005, 16'h0003, 16'h0001, 16'hFFFE},
            {2'd0, 2'd0, 2'd0, 2'd3}, "R7 word wrap 256K");
    // R5 R3: byte pass-through and 16-bit wrap
    run_seq(16'hFFFE, 0, 0, 0, 1, 0, {16'h0001, 16'h0000, 16'hFFFF, 16'hFFFE},
            {2'd0, 2'd0, 2'd3, 2'd3}, "R5_R3 byte wrap");
    // R4 R11 R10: count by two, mode pins flipped mid-frame
    run_seq(16'h0100, 1, 0, 0, 0, 1, {16'h0101, 16'h0101, 16'h0100, 16'h0100},
            {2'd0, 2'd0, 2'd0, 2'd0}, "R4_R11_R10 by-two, mid-frame change");

    // random mix compared with the model every clock
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      frame_start  = ($urandom_range(0, 39) == 0);
      char_clk_en  = ($urandom_range(0, 2) != 0);
      start_addr   = 16'($urandom);
      count_by_two = 1'($urandom);
      word_mode    = 1'($urandom);
      addr_wrap    = 1'($urandom);
      mem_256k     = 1'($urandom);
    end
    @(negedge clk);
    frame_start = 1'b0; char_clk_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule